// File: doc/BRIEF.md
# Two-Level Windowed Register File

This block is the integer register file of a fine-grain multithreaded core whose register windows overlap. Each thread sees 32 architectural registers at a time. A small, heavily ported first-level array holds only the window that is active for each thread, and that array serves every pipeline read and write. A larger single-ported backing store keeps every window of every thread. A window's out registers are the same storage as the in registers of the window above it. The eight globals of each thread never leave the first level.

A window move is started by a request that names the thread and the direction. A save moves to the next window and a restore moves to the previous one, and window numbers wrap around at both ends. A sequencer copies the active out, local and in registers into the backing store, one word per cycle. It then fills the first level from the target window, also one word per cycle. It raises busy for the whole transfer. Handling of overflow and underflow, and stalling the pipeline around a move, are left to the surrounding core.

Top module: `twin_regfile`

## Requirements
- R1: After reset every register of every thread and every window reads zero, and busy_o is low.
- R2: Architectural index 0 (global 0) always reads zero, and writes to it are discarded.
- R3: Indices map as 0–7 global, 8–15 out, 16–23 local, 24–31 in. A write on either write port (port 0 for short-latency results, port 1 for long-latency results) to thread t, index a, is returned by a read of t, a from the next cycle on.
- R4: When both write ports write the same thread and index in the same cycle, the value on port 1 is kept.
- R5: The NRD read ports are independent and combinational. Each returns its own thread and index in the same cycle.
- R6: Threads have separate registers, so a write to one thread never changes the value that another thread reads.
- R7: After a save (win_save_i=1) that starts from window w, the new in registers (24–31) hold the old out registers (8–15), and the locals are those stored for window w+1.
- R8: A restore (win_save_i=0) that follows a save brings back the caller's locals and ins. The caller's outs then hold whatever the callee left in its ins.
- R9: The globals (1–7) of a thread are unchanged by its window moves.
- R10: An accepted request raises busy_o in the next cycle, and busy_o then stays high for exactly 48 cycles: 24 spill steps followed by 24 fill steps.
- R11: Window numbers wrap. A restore from window 0 moves to window NWIN-1, whose out registers show the in registers of window 0.
- R12: A window request made while busy_o is high is ignored.
- R13: While busy_o is high, pipeline writes to the thread being transferred are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_thr_i | input | NRD*TW | Thread of each read port |
| rd_addr_i | input | NRD*5 | Architectural index of each read port |
| rd_data_o | output | NRD*DW | Read data of each port |
| wr_en_i | input | 2 | Write enables: bit 0 short-latency, bit 1 long-latency |
| wr_thr_i | input | 2*TW | Thread of each write port |
| wr_addr_i | input | 10 | Architectural index of each write port |
| wr_data_i | input | 2*DW | Write data of each port |
| win_req_i | input | 1 | Request a window move |
| win_save_i | input | 1 | 1 = save (next window), 0 = restore (previous window) |
| win_thr_i | input | TW | Thread whose window moves |
| busy_o | output | 1 | Transfer in progress |

## Verification
The bench builds the block with two threads, four windows and 16-bit data. These sizes keep the window wrap at the lower boundary, and thread isolation, within a short run while the transfer length stays at its full 48 cycles. The stimulus writes one value per window group. It then follows the values through a save, the matching restore and a wrapping restore. A second request and a late pipeline write are placed inside a transfer, at times where a wrong design would leave a visible trace.

// File: rtl/twr_pkg.sv
package twr_pkg;
  localparam int GRP_REGS   = 8;
  localparam int XFER_STEPS = 3 * GRP_REGS;   // out, local, in
  localparam int XFER_CYC   = 2 * XFER_STEPS; // spill then fill

  typedef enum logic [1:0] {
    GRP_OUT = 2'd0,
    GRP_LOC = 2'd1,
    GRP_IN  = 2'd2
  } grp_e;
endpackage

// File: rtl/twr_l1.sv
module twr_l1 #(
  parameter int NTHR = 4,
  parameter int DW   = 32,
  parameter int NRD  = 3,
  parameter int TW   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NRD*TW-1:0] rd_thr_i,
  input  logic [NRD*5-1:0]  rd_addr_i,
  output logic [NRD*DW-1:0] rd_data_o,
  input  logic [1:0]        wr_en_i,
  input  logic [2*TW-1:0]   wr_thr_i,
  input  logic [9:0]        wr_addr_i,
  input  logic [2*DW-1:0]   wr_data_i,
  input  logic              fl_en_i,
  input  logic [TW-1:0]     xf_thr_i,
  input  logic [4:0]        xf_idx_i,
  input  logic [DW-1:0]     fl_data_i,
  output logic [DW-1:0]     sp_data_o
);
  localparam int DEPTH = NTHR * 32;

  logic [DW-1:0] mem_q [DEPTH];

  // port 1 (long latency) is applied after port 0, so it wins a tie
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      for (int k = 0; k < 2; k++) begin
        if (wr_en_i[k] && wr_addr_i[k*5+:5] != 5'd0)
          mem_q[int'(wr_thr_i[k*TW+:TW])*32 + int'(wr_addr_i[k*5+:5])] <= wr_data_i[k*DW+:DW];
      end
      if (fl_en_i)
        mem_q[int'(xf_thr_i)*32 + int'(xf_idx_i)] <= fl_data_i;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_data_o[p*DW+:DW] =
      mem_q[int'(rd_thr_i[p*TW+:TW])*32 + int'(rd_addr_i[p*5+:5])];
  end

  assign sp_data_o = mem_q[int'(xf_thr_i)*32 + int'(xf_idx_i)];
endmodule

// File: rtl/twr_bstore.sv
module twr_bstore #(
  parameter int NTHR = 4,
  parameter int NWIN = 8,
  parameter int DW   = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  int            addr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  // per thread and window: 8 locals then 8 ins
  localparam int DEPTH = NTHR * NWIN * 16;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/twr_seq.sv
module twr_seq
  import twr_pkg::*;
#(
  parameter int NTHR = 4,
  parameter int NWIN = 8,
  parameter int TW   = 2,
  parameter int WW   = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          save_i,
  input  logic [TW-1:0] thr_i,
  output logic          busy_o,
  output logic [TW-1:0] thr_o,
  output logic          spill_o,
  output logic [4:0]    l1_idx_o,
  output logic [WW-1:0] bk_win_o,
  output logic          bk_in_o,
  output logic [2:0]    bk_r_o
);
  localparam int CW = $clog2(XFER_CYC);

  logic [WW-1:0] cwp_q [NTHR];
  logic          act_q;
  logic [CW-1:0] ctr_q;
  logic [TW-1:0] thr_q;
  logic [WW-1:0] old_q, new_q;

  function automatic logic [WW-1:0] win_nxt(input logic [WW-1:0] w);
    return (int'(w) == NWIN - 1) ? '0 : w + 1'b1;
  endfunction

  function automatic logic [WW-1:0] win_prv(input logic [WW-1:0] w);
    return (w == '0) ? WW'(NWIN - 1) : w - 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int t = 0; t < NTHR; t++) cwp_q[t] <= '0;
      act_q <= 1'b0;
      ctr_q <= '0;
      thr_q <= '0;
      old_q <= '0;
      new_q <= '0;
    end else if (!act_q) begin
      if (req_i) begin
        act_q <= 1'b1;
        ctr_q <= '0;
        thr_q <= thr_i;
        old_q <= cwp_q[thr_i];
        new_q <= save_i ? win_nxt(cwp_q[thr_i]) : win_prv(cwp_q[thr_i]);
      end
    end else if (int'(ctr_q) == XFER_CYC - 1) begin
      act_q        <= 1'b0;
      cwp_q[thr_q] <= new_q;
    end else begin
      ctr_q <= ctr_q + 1'b1;
    end
  end

  logic [4:0]    step;
  logic [1:0]    grp;
  logic [WW-1:0] base;

  always_comb begin
    spill_o  = int'(ctr_q) < XFER_STEPS;
    step     = spill_o ? 5'(ctr_q) : 5'(int'(ctr_q) - XFER_STEPS);
    grp      = step[4:3];
    base     = spill_o ? old_q : new_q;
    // outs of window w live as the ins of window w+1
    bk_win_o = (grp == GRP_OUT) ? win_nxt(base) : base;
    bk_in_o  = (grp != GRP_LOC);
    bk_r_o   = step[2:0];
    l1_idx_o = {grp + 2'd1, step[2:0]};
  end

  assign busy_o = act_q;
  assign thr_o  = thr_q;
endmodule

// File: rtl/twin_regfile.sv
module twin_regfile #(
  parameter int NTHR = 4,
  parameter int NWIN = 8,
  parameter int DW   = 32,
  parameter int NRD  = 3,
  localparam int TW  = (NTHR > 1) ? $clog2(NTHR) : 1,
  localparam int WW  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NRD*TW-1:0] rd_thr_i,
  input  logic [NRD*5-1:0]  rd_addr_i,
  output logic [NRD*DW-1:0] rd_data_o,
  input  logic [1:0]        wr_en_i,
  input  logic [2*TW-1:0]   wr_thr_i,
  input  logic [9:0]        wr_addr_i,
  input  logic [2*DW-1:0]   wr_data_i,
  input  logic              win_req_i,
  input  logic              win_save_i,
  input  logic [TW-1:0]     win_thr_i,
  output logic              busy_o
);
  logic          busy, spill, bk_in;
  logic [TW-1:0] xthr;
  logic [4:0]    l1_idx;
  logic [WW-1:0] bk_win;
  logic [2:0]    bk_r;
  logic [DW-1:0] sp_data, bk_rdata;
  logic [1:0]    wr_en_g;
  int            bk_addr;

  twr_seq #(.NTHR(NTHR), .NWIN(NWIN), .TW(TW), .WW(WW)) u_seq (
    .clk_i, .rst_ni,
    .req_i(win_req_i), .save_i(win_save_i), .thr_i(win_thr_i),
    .busy_o(busy), .thr_o(xthr), .spill_o(spill), .l1_idx_o(l1_idx),
    .bk_win_o(bk_win), .bk_in_o(bk_in), .bk_r_o(bk_r)
  );

  // drop pipeline writes into the thread under transfer
  for (genvar k = 0; k < 2; k++) begin : g_wgate
    assign wr_en_g[k] = wr_en_i[k] && !(busy && wr_thr_i[k*TW+:TW] == xthr);
  end

  assign bk_addr = ((int'(xthr) * NWIN + int'(bk_win)) * 2 + int'(bk_in)) * 8 + int'(bk_r);

  twr_l1 #(.NTHR(NTHR), .DW(DW), .NRD(NRD), .TW(TW)) u_l1 (
    .clk_i, .rst_ni,
    .rd_thr_i, .rd_addr_i, .rd_data_o,
    .wr_en_i(wr_en_g), .wr_thr_i, .wr_addr_i, .wr_data_i,
    .fl_en_i(busy && !spill), .xf_thr_i(xthr), .xf_idx_i(l1_idx),
    .fl_data_i(bk_rdata), .sp_data_o(sp_data)
  );

  twr_bstore #(.NTHR(NTHR), .NWIN(NWIN), .DW(DW)) u_bk (
    .clk_i, .rst_ni,
    .addr_i(bk_addr), .we_i(busy && spill), .wdata_i(sp_data), .rdata_o(bk_rdata)
  );

  assign busy_o = busy;
endmodule

// File: rtl/twin_regfile_chk.sv
module twin_regfile_chk #(
  parameter int NTHR = 4,
  parameter int DW   = 32,
  parameter int NRD  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NRD*5-1:0]  rd_addr_i,
  input logic [NRD*DW-1:0] rd_data_o,
  input logic              win_req_i,
  input logic              busy_o
);
  logic [7:0] bcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bcnt_q <= '0;
    else         bcnt_q <= busy_o ? bcnt_q + 8'd1 : 8'd0;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_zero
    p_g0_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_addr_i[p*5+:5] == 5'd0 |-> rd_data_o[p*DW+:DW] == '0);
  end

  p_busy_len_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> bcnt_q == 8'(twr_pkg::XFER_CYC));

  p_accept_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_req_i && !busy_o |=> busy_o);

  p_rise_req_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(win_req_i));
endmodule

bind twin_regfile twin_regfile_chk #(.NTHR(NTHR), .DW(DW), .NRD(NRD)) u_chk (
  .clk_i, .rst_ni, .rd_addr_i, .rd_data_o, .win_req_i, .busy_o
);

// File: tb/tb_twin_regfile.sv
`timescale 1ns/1ps
module tb_twin_regfile;
  localparam int NTHR = 2, NWIN = 4, DW = 16, NRD = 3, TW = 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NRD*TW-1:0] rd_thr = '0;
  logic [NRD*5-1:0]  rd_addr = '0;
  logic [NRD*DW-1:0] rd_data;
  logic [1:0]        wr_en = '0;
  logic [2*TW-1:0]   wr_thr = '0;
  logic [9:0]        wr_addr = '0;
  logic [2*DW-1:0]   wr_data = '0;
  logic              win_req = 1'b0, win_save = 1'b0;
  logic [TW-1:0]     win_thr = '0;
  logic              busy;

  int n_chk = 0, n_fail = 0;
  int q_port[$];
  logic [DW-1:0] q_exp[$];
  string q_tag[$];

  always #2 clk = ~clk;

  twin_regfile #(.NTHR(NTHR), .NWIN(NWIN), .DW(DW), .NRD(NRD)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_thr_i(rd_thr), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .wr_en_i(wr_en), .wr_thr_i(wr_thr), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .win_req_i(win_req), .win_save_i(win_save), .win_thr_i(win_thr), .busy_o(busy)
  );

  // monitor: compare every pending expectation at the falling edge
  always @(negedge clk) begin
    while (q_port.size() > 0) begin
      int p;
      logic [DW-1:0] e, a;
      string t;
      p = q_port.pop_front(); e = q_exp.pop_front(); t = q_tag.pop_front();
      a = rd_data[p*DW+:DW];
      n_chk++;
      if (a !== e) begin
        n_fail++;
        $display("FAIL %s port%0d actual=%h expected=%h", t, p, a, e);
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_rd(input int p, input int thr, input int addr);
    rd_thr[p*TW+:TW] = TW'(thr);
    rd_addr[p*5+:5]  = 5'(addr);
  endtask

  task automatic rd1(input int thr, input int addr, input logic [DW-1:0] exp, input string tag);
    @(posedge clk); #1;
    set_rd(0, thr, addr);
    q_port.push_back(0); q_exp.push_back(exp); q_tag.push_back(tag);
    @(negedge clk);
  endtask

  task automatic rd3(input int thr, input int a0, input int a1, input int a2,
                     input logic [DW-1:0] e0, input logic [DW-1:0] e1,
                     input logic [DW-1:0] e2, input string tag);
    @(posedge clk); #1;
    set_rd(0, thr, a0); set_rd(1, thr, a1); set_rd(2, thr, a2);
    q_port.push_back(0); q_exp.push_back(e0); q_tag.push_back(tag);
    q_port.push_back(1); q_exp.push_back(e1); q_tag.push_back(tag);
    q_port.push_back(2); q_exp.push_back(e2); q_tag.push_back(tag);
    @(negedge clk);
  endtask

  task automatic drive_wr(input int p, input int thr, input int addr, input logic [DW-1:0] d);
    wr_en[p] = 1'b1;
    wr_thr[p*TW+:TW] = TW'(thr);
    wr_addr[p*5+:5]  = 5'(addr);
    wr_data[p*DW+:DW] = d;
  endtask

  task automatic wr(input int p, input int thr, input int addr, input logic [DW-1:0] d);
    @(posedge clk); #1;
    drive_wr(p, thr, addr, d);
    @(posedge clk); #1;
    wr_en = '0;
  endtask

  task automatic win_op(input int thr, input logic save, output int cyc);
    @(posedge clk); #1;
    win_req = 1'b1; win_save = save; win_thr = TW'(thr);
    @(posedge clk); #1;
    win_req = 1'b0;
    cyc = 0;
    forever begin
      @(negedge clk);
      if (busy) cyc++;
      else break;
    end
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cyc;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    check("R1 busy after reset", int'(busy), 0);
    rd3(0, 8, 16, 31, 16'h0, 16'h0, 16'h0, "R1");
    rd1(1, 24, 16'h0, "R1");

    // R2 global 0
    wr(0, 0, 0, 16'h1234);
    rd1(0, 0, 16'h0, "R2");

    // R3 one value per group, both ports
    wr(0, 0, 1, 16'h0101);
    wr(1, 0, 8, 16'h0808);
    wr(0, 0, 16, 16'h1616);
    wr(1, 0, 24, 16'h2424);
    rd1(0, 1, 16'h0101, "R3");
    rd1(0, 8, 16'h0808, "R3");
    rd1(0, 16, 16'h1616, "R3");
    rd1(0, 24, 16'h2424, "R3");

    // R4 same target on both ports
    @(posedge clk); #1;
    drive_wr(0, 0, 17, 16'hAAAA);
    drive_wr(1, 0, 17, 16'h5555);
    @(posedge clk); #1;
    wr_en = '0;
    rd1(0, 17, 16'h5555, "R4");

    // R5 three ports at once
    rd3(0, 1, 8, 16, 16'h0101, 16'h0808, 16'h1616, "R5");

    // R6 thread isolation
    wr(1, 1, 16, 16'h7777);
    rd1(0, 16, 16'h1616, "R6");
    rd1(1, 16, 16'h7777, "R6");

    // R10 save, transfer length
    win_op(0, 1'b1, cyc);
    check("R10 busy cycles", cyc, 48);

    // R7 outs became ins, fresh locals; R9 globals kept
    rd1(0, 24, 16'h0808, "R7");
    rd1(0, 16, 16'h0000, "R7");
    rd1(0, 17, 16'h0000, "R7");
    rd1(0, 1, 16'h0101, "R9");

    wr(1, 0, 24, 16'h3333);
    wr(0, 0, 16, 16'h4444);

    // R8 restore
    win_op(0, 1'b0, cyc);
    check("R10 busy cycles restore", cyc, 48);
    rd1(0, 8, 16'h3333, "R8");
    rd1(0, 16, 16'h1616, "R8");
    rd1(0, 17, 16'h5555, "R8");
    rd1(0, 24, 16'h2424, "R8");
    rd1(0, 1, 16'h0101, "R9");

    // R11 wrapping restore, with R12 / R13 stimulus inside the transfer
    @(posedge clk); #1;
    win_req = 1'b1; win_save = 1'b0; win_thr = '0;
    @(posedge clk); #1;               // accepted
    win_req = 1'b0;
    repeat (2) @(posedge clk);
    #1 win_req = 1'b1; win_save = 1'b1;   // R12: must be ignored
    @(posedge clk); #1;
    win_req = 1'b0;
    repeat (41) @(posedge clk);
    #1 drive_wr(0, 0, 16, 16'hDEAD);      // R13: lands after locals fill
    @(posedge clk); #1;
    wr_en = '0;
    forever begin
      @(negedge clk);
      if (!busy) break;
    end
    rd1(0, 8, 16'h2424, "R11");
    rd1(0, 8, 16'h2424, "R12");
    rd1(0, 16, 16'h0000, "R13");
    rd1(0, 1, 16'h0101, "R9");
    rd1(1, 16, 16'h7777, "R6");
    rd1(0, 0, 16'h0000, "R2");

    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule